// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers asynchronous serial frames from a single input line. It runs on a free-running clock. An integer clocks-per-bit value sets the bit cell, and every field of the frame is sampled once, at a programmable point within its cell. The line first passes through a two-flop synchronizer, and can optionally be inverted there. A falling edge on the result opens a frame. The start bit is then confirmed, and the data bits, an optional parity bit and zero, one or two stop bits follow.

At the sample instant of the frame's last field the block emits several outputs together. They are the assembled data word, a parity-error flag, a framing-error flag, an overall frame-good flag and a one-cycle completion strobe. If the start bit fails its confirmation, the block emits a strobe at once and returns to looking for a new falling edge. Configuration inputs are expected to stay stable while a frame is in flight.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is high and after it is released, the strobe is low and the data word, both error flags and the frame-good flag read zero until the first frame completes.
- R2: A frame opens only on a high-to-low transition of the line after optional inversion. With inversion enabled (cfg_invert_i=1), the physical line idles low and a rising physical edge opens the frame.
- R3: With the line changing to the start level just after clock edge P, field slot n (slot 0 = start bit, then data, then parity, then stop bits) is sampled at edge P+4+off+n*C. Here C is clocks-per-bit and off = floor((C-1)*pct/100). The strobe is high just after the edge that samples the last slot.
- R4: A sample-point percentage outside 1..99, including 0, behaves exactly like 50.
- R5: If the start slot samples high, the block strobes at that edge with data 0, framing error 1, parity error 0 and frame-good 0. It then waits for a new falling edge, and the next well-formed frame is received normally.
- R6: Data width is 5..9 bits. With cfg_msb_first_i=0 the first received data bit becomes bit 0 of the word. With cfg_msb_first_i=1 the first received bit becomes the top bit of the configured width. Bits above the configured width are always zero.
- R7: Parity code 1 (odd) passes when the data ones plus the parity bit total odd. Code 2 (even) passes when they total even. A failing check sets the parity-error flag and clears frame-good.
- R8: Parity code 3 requires the parity bit to be 0, and code 4 requires it to be 1. Code 5 accepts any parity bit and never raises a parity error.
- R9: Parity code 0 omits the parity slot. A stop count of 0 completes the frame at the sample of the last data or parity slot. A stop count of 2 adds two stop slots.
- R10: A stop slot that samples 0 sets the framing-error flag and clears frame-good. Reception still continues to the last stop slot, and the strobe comes at that slot's sample.
- R11: The completion strobe is high for exactly one cycle per frame and never without a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_i | input | 1 | Asynchronous serial line |
| cfg_clks_per_bit_i | input | CPB_W | Clock cycles per bit cell, at least 2 |
| cfg_data_bits_i | input | 4 | Data width 5..9 (values below 5 or above 9 are clamped) |
| cfg_parity_i | input | 3 | 0 none, 1 odd, 2 even, 3 stuck zero, 4 stuck one, 5 ignore; 6 and 7 act as none |
| cfg_stop_bits_i | input | 2 | Stop slots 0, 1 or 2; 3 acts as 2 |
| cfg_msb_first_i | input | 1 | 1 = first data bit received is the most significant |
| cfg_invert_i | input | 1 | 1 = line is inverted before edge detection |
| cfg_sample_pct_i | input | 7 | Sample point in percent of the bit cell |
| frame_data_o | output | 9 | Received data word, zero-filled above the width |
| frame_par_err_o | output | 1 | Parity check failed for the last frame |
| frame_frm_err_o | output | 1 | Start or stop slot had the wrong level |
| frame_ok_o | output | 1 | Last frame had no error |
| frame_done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong bit-timer count shifts every sample instant. The shift shows up as a strobe at the wrong cycle, typically one bit cell after the first affected slot. A stale state in the field sequencer either skips or repeats a slot, and this moves the strobe by whole multiples of the bit cell. A mistaken shift direction or parity decision changes the word or the flags, and this is visible at the very strobe of the frame concerned. The reference model predicts the exact strobe cycle and field values from the line stimulus. It compares them on every clock, so a missing or extra strobe is reported within the same frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned MAX_DATA_BITS = 9;
    localparam int unsigned NB_W          = 4;
    localparam int unsigned PCT_W         = 7;
    localparam logic [PCT_W-1:0] PCT_FALLBACK = 7'd50;

    typedef enum logic [2:0] {
        PAR_NONE   = 3'd0,
        PAR_ODD    = 3'd1,
        PAR_EVEN   = 3'd2,
        PAR_ZERO   = 3'd3,
        PAR_ONE    = 3'd4,
        PAR_IGNORE = 3'd5
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [MAX_DATA_BITS-1:0] word;
        logic                     par_err;
        logic                     frm_err;
        logic                     ok;
    } rx_result_t;

    function automatic logic [PCT_W-1:0] eff_pct(input logic [PCT_W-1:0] pct);
        if (pct >= 7'd1 && pct <= 7'd99) return pct;
        return PCT_FALLBACK;
    endfunction

    function automatic logic [NB_W-1:0] eff_data_bits(input logic [NB_W-1:0] nb);
        if (nb < 4'd5) return 4'd5;
        if (nb > 4'd9) return 4'd9;
        return nb;
    endfunction

    function automatic logic [1:0] eff_stop_bits(input logic [1:0] ns);
        return (ns == 2'd3) ? 2'd2 : ns;
    endfunction

    function automatic par_mode_e decode_parity(input logic [2:0] raw);
        case (raw)
            3'd1:    return PAR_ODD;
            3'd2:    return PAR_EVEN;
            3'd3:    return PAR_ZERO;
            3'd4:    return PAR_ONE;
            3'd5:    return PAR_IGNORE;
            default: return PAR_NONE;
        endcase
    endfunction

    function automatic logic parity_pass(input par_mode_e mode,
                                         input logic [MAX_DATA_BITS-1:0] word,
                                         input logic pbit);
        case (mode)
            PAR_ODD:  return (^word ^ pbit) == 1'b1;
            PAR_EVEN: return (^word ^ pbit) == 1'b0;
            PAR_ZERO: return !pbit;
            PAR_ONE:  return pbit;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic invert_i,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= line_i ^ invert_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
    import serial_rx_pkg::*;
#(
    parameter int unsigned CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CPB_W-1:0] cpb_i,
    input  logic [PCT_W-1:0] pct_i,
    input  logic             load_i,
    input  logic             run_i,
    output logic             tick_o
);

    localparam int unsigned PROD_W = CPB_W + PCT_W;

    logic [PROD_W-1:0] prod;
    logic [CPB_W-1:0]  offset;
    logic [CPB_W-1:0]  cnt_q;

    always_comb begin
        prod   = PROD_W'(cpb_i - 1'b1) * PROD_W'(eff_pct(pct_i));
        offset = CPB_W'(prod / PROD_W'(100));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= offset;
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= cpb_i - 1'b1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R3: the sample offset always lands inside the bit cell
    p_offset_in_cell_r3: assert property (@(posedge clk) disable iff (rst)
        (load_i && cpb_i >= CPB_W'(2)) |-> (offset < cpb_i));

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import serial_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            level_i,
    input  logic            fall_i,
    input  logic            tick_i,
    input  logic [NB_W-1:0] nb_i,
    input  par_mode_e       par_mode_i,
    input  logic [1:0]      nstop_i,
    input  logic            msb_first_i,
    output logic            load_o,
    output logic            busy_o,
    output logic            done_o,
    output rx_result_t      result_o
);

    rx_state_e                state_q, state_n;
    logic [NB_W-1:0]          idx_q, idx_n;
    logic [MAX_DATA_BITS-1:0] word_q, word_n;
    logic                     perr_q, perr_n;
    logic                     ferr_q, ferr_n;
    logic                     finish, bad_start;
    logic                     done_q;
    rx_result_t               res_q;

    always_comb begin
        state_n   = state_q;
        idx_n     = idx_q;
        word_n    = word_q;
        perr_n    = perr_q;
        ferr_n    = ferr_q;
        finish    = 1'b0;
        bad_start = 1'b0;
        case (state_q)
            ST_HUNT: begin
                if (fall_i) state_n = ST_START;
            end
            ST_START: begin
                if (tick_i) begin
                    if (level_i) begin
                        bad_start = 1'b1;
                        state_n   = ST_HUNT;
                    end else begin
                        state_n = ST_DATA;
                        idx_n   = '0;
                        word_n  = '0;
                        perr_n  = 1'b0;
                        ferr_n  = 1'b0;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (msb_first_i) word_n = {word_q[MAX_DATA_BITS-2:0], level_i};
                    else             word_n = word_q | (MAX_DATA_BITS'(level_i) << idx_q);
                    if (idx_q == nb_i - 1'b1) begin
                        idx_n = '0;
                        if (par_mode_i != PAR_NONE) state_n = ST_PAR;
                        else if (nstop_i != 2'd0)   state_n = ST_STOP;
                        else                        finish  = 1'b1;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    perr_n = !parity_pass(par_mode_i, word_q, level_i);
                    idx_n  = '0;
                    if (nstop_i != 2'd0) state_n = ST_STOP;
                    else                 finish  = 1'b1;
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (!level_i) ferr_n = 1'b1;
                    if (idx_q == NB_W'(nstop_i - 2'd1)) finish = 1'b1;
                    else                               idx_n  = idx_q + 1'b1;
                end
            end
            default: state_n = ST_HUNT;
        endcase
        if (finish) state_n = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
            word_q  <= '0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            word_q  <= word_n;
            perr_q  <= perr_n;
            ferr_q  <= ferr_n;
            done_q  <= finish | bad_start;
            if (finish) begin
                res_q.word    <= word_n;
                res_q.par_err <= perr_n;
                res_q.frm_err <= ferr_n;
                res_q.ok      <= !(perr_n || ferr_n);
            end else if (bad_start) begin
                res_q.word    <= '0;
                res_q.par_err <= 1'b0;
                res_q.frm_err <= 1'b1;
                res_q.ok      <= 1'b0;
            end
        end
    end

    assign load_o   = (state_q == ST_HUNT) && fall_i;
    assign busy_o   = (state_q != ST_HUNT);
    assign done_o   = done_q;
    assign result_o = res_q;

    // R11: completion strobe lasts a single cycle
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: a frame only opens after a detected falling edge
    p_open_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(fall_i));

    // R6: bits above the configured width stay clear
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((result_o.word >> nb_i) == '0));

    // R8: unchecked parity modes never report a parity error
    p_unchecked_parity_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && (par_mode_i == PAR_NONE || par_mode_i == PAR_IGNORE)) |-> !result_o.par_err);

    // R5: a high start sample yields an errored strobe on the next cycle
    p_bad_start_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick_i && level_i) |=>
            (done_o && result_o.frm_err && !result_o.ok && result_o.word == '0));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import serial_rx_pkg::*;
#(
    parameter int unsigned CPB_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_line_i,
    input  logic [CPB_W-1:0]         cfg_clks_per_bit_i,
    input  logic [NB_W-1:0]          cfg_data_bits_i,
    input  logic [2:0]               cfg_parity_i,
    input  logic [1:0]               cfg_stop_bits_i,
    input  logic                     cfg_msb_first_i,
    input  logic                     cfg_invert_i,
    input  logic [PCT_W-1:0]         cfg_sample_pct_i,
    output logic [MAX_DATA_BITS-1:0] frame_data_o,
    output logic                     frame_par_err_o,
    output logic                     frame_frm_err_o,
    output logic                     frame_ok_o,
    output logic                     frame_done_o
);

    logic       level, fall, tick, load, busy;
    rx_result_t result;

    rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .line_i   (rx_line_i),
        .invert_i (cfg_invert_i),
        .level_o  (level),
        .fall_o   (fall)
    );

    rx_bit_timer #(.CPB_W(CPB_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .cpb_i  (cfg_clks_per_bit_i),
        .pct_i  (cfg_sample_pct_i),
        .load_i (load),
        .run_i  (busy),
        .tick_o (tick)
    );

    rx_frame_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .level_i     (level),
        .fall_i      (fall),
        .tick_i      (tick),
        .nb_i        (eff_data_bits(cfg_data_bits_i)),
        .par_mode_i  (decode_parity(cfg_parity_i)),
        .nstop_i     (eff_stop_bits(cfg_stop_bits_i)),
        .msb_first_i (cfg_msb_first_i),
        .load_o      (load),
        .busy_o      (busy),
        .done_o      (frame_done_o),
        .result_o    (result)
    );

    assign frame_data_o    = result.word;
    assign frame_par_err_o = result.par_err;
    assign frame_frm_err_o = result.frm_err;
    assign frame_ok_o      = result.ok;

endmodule

// File: tb/serial_frame_rx_tb_top.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic [15:0] cpb = 16'd8;
    logic [3:0]  nbits = 4'd8;
    logic [2:0]  pmode = 3'd0;
    logic [1:0]  nstop = 2'd1;
    logic        msb = 1'b0;
    logic        inv = 1'b0;
    logic [6:0]  pct = 7'd50;

    logic [8:0]  frame_data_o;
    logic        frame_par_err_o, frame_frm_err_o, frame_ok_o, frame_done_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    int    q_cyc[$];
    int    q_data[$];
    bit    q_perr[$];
    bit    q_ferr[$];
    bit    q_ok[$];
    string q_tag[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    serial_frame_rx dut_i (
        .clk                (clk),
        .rst                (rst),
        .rx_line_i          (line),
        .cfg_clks_per_bit_i (cpb),
        .cfg_data_bits_i    (nbits),
        .cfg_parity_i       (pmode),
        .cfg_stop_bits_i    (nstop),
        .cfg_msb_first_i    (msb),
        .cfg_invert_i       (inv),
        .cfg_sample_pct_i   (pct),
        .frame_data_o       (frame_data_o),
        .frame_par_err_o    (frame_par_err_o),
        .frame_frm_err_o    (frame_frm_err_o),
        .frame_ok_o         (frame_ok_o),
        .frame_done_o       (frame_done_o)
    );

    // reference model comparison on every clock (R3 timing, R11 strobe)
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_done_o) begin
                checks++;
                if (q_cyc.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected strobe at cycle %0d actual=1 expected=0", cyc);
                end else begin
                    if (q_cyc[0] != cyc || int'(frame_data_o) != q_data[0] ||
                        frame_par_err_o != q_perr[0] || frame_frm_err_o != q_ferr[0] ||
                        frame_ok_o != q_ok[0]) begin
                        errors++;
                        $display("FAIL %s actual cyc=%0d data=%03h pe=%0b fe=%0b ok=%0b expected cyc=%0d data=%03h pe=%0b fe=%0b ok=%0b",
                                 q_tag[0], cyc, frame_data_o, frame_par_err_o, frame_frm_err_o, frame_ok_o,
                                 q_cyc[0], q_data[0], q_perr[0], q_ferr[0], q_ok[0]);
                    end
                    void'(q_cyc.pop_front()); void'(q_data.pop_front());
                    void'(q_perr.pop_front()); void'(q_ferr.pop_front());
                    void'(q_ok.pop_front()); void'(q_tag.pop_front());
                end
            end else if (q_cyc.size() > 0 && cyc > q_cyc[0]) begin
                checks++;
                errors++;
                $display("FAIL %s R11 missing strobe actual=none expected cyc=%0d", q_tag[0], q_cyc[0]);
                void'(q_cyc.pop_front()); void'(q_data.pop_front());
                void'(q_perr.pop_front()); void'(q_ferr.pop_front());
                void'(q_ok.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    function automatic int offset_of(input int c, input int p);
        int pe;
        pe = (p >= 1 && p <= 99) ? p : 50;
        return ((c - 1) * pe) / 100;
    endfunction

    task automatic configure(input int nb, input int pm, input int ns, input bit m,
                             input bit iv, input int pc, input int c);
        @(negedge clk);
        nbits = 4'(nb); pmode = 3'(pm); nstop = 2'(ns); msb = m;
        inv = iv; pct = 7'(pc); cpb = 16'(c);
        line = 1'b1 ^ iv;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(input int data, input int nb, input int pm, input int ns,
                              input bit m, input bit iv, input int pc, input int c,
                              input bit flip_par, input int bad_stop, input string tag);
        int  slots[$];
        int  dm, ones, pbit, last, start_cyc;
        bit  perr, ferr;
        configure(nb, pm, ns, m, iv, pc, c);
        dm = data & ((1 << nb) - 1);
        ones = 0;
        for (int i = 0; i < nb; i++) ones += (dm >> i) & 1;
        slots.push_back(0);
        for (int i = 0; i < nb; i++) slots.push_back(m ? ((dm >> (nb - 1 - i)) & 1) : ((dm >> i) & 1));
        perr = 1'b0;
        if (pm >= 1 && pm <= 5) begin
            case (pm)
                1: pbit = (ones % 2 == 0) ? 1 : 0;
                2: pbit = ones % 2;
                4: pbit = 1;
                default: pbit = 0;
            endcase
            if (flip_par) begin
                pbit = pbit ^ 1;
                perr = (pm != 5);
            end
            slots.push_back(pbit);
        end
        ferr = 1'b0;
        for (int i = 0; i < ns; i++) begin
            if ((bad_stop >> i) & 1) begin
                slots.push_back(0);
                ferr = 1'b1;
            end else begin
                slots.push_back(1);
            end
        end
        last = slots.size() - 1;
        start_cyc = cyc;
        q_cyc.push_back(start_cyc + 4 + offset_of(c, pc) + last * c);
        q_data.push_back(dm); q_perr.push_back(perr); q_ferr.push_back(ferr);
        q_ok.push_back(!(perr || ferr)); q_tag.push_back(tag);
        foreach (slots[k]) begin
            line = 1'(slots[k]) ^ iv;
            repeat (c) @(negedge clk);
        end
        line = 1'b1 ^ iv;
        repeat (3 * c + 6) @(negedge clk);
    endtask

    task automatic glitch(input int pc, input int c, input string tag);
        configure(8, 0, 1, 1'b0, 1'b0, pc, c);
        q_cyc.push_back(cyc + 4 + offset_of(c, pc));
        q_data.push_back(0); q_perr.push_back(1'b0); q_ferr.push_back(1'b1);
        q_ok.push_back(1'b0); q_tag.push_back(tag);
        line = 1'b0;
        repeat (2) @(negedge clk);
        line = 1'b1;
        repeat (4 * c) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (frame_done_o !== 1'b0 || frame_data_o !== 9'd0 || frame_par_err_o !== 1'b0 ||
            frame_frm_err_o !== 1'b0 || frame_ok_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual done=%0b data=%03h pe=%0b fe=%0b ok=%0b expected all zero",
                     frame_done_o, frame_data_o, frame_par_err_o, frame_frm_err_o, frame_ok_o);
        end

        send_frame(9'h0A5, 8, 0, 1, 0, 0, 50, 8, 0, 0, "R2 R3 R6 lsb-first 8N1");
        send_frame(9'h03C, 8, 0, 1, 1, 0, 50, 8, 0, 0, "R6 msb-first 8N1");
        send_frame(9'h013, 5, 2, 1, 0, 0, 50, 10, 0, 0, "R7 even 5-bit");
        send_frame(9'h1A5, 9, 1, 1, 0, 0, 50, 10, 0, 0, "R7 odd 9-bit");
        send_frame(9'h1A5, 9, 1, 1, 1, 0, 50, 10, 1, 0, "R7 odd error msb-first");
        send_frame(9'h055, 7, 2, 1, 0, 0, 50, 8, 1, 0, "R7 even error");
        send_frame(9'h02B, 6, 3, 1, 0, 0, 50, 8, 0, 0, "R8 stuck zero pass");
        send_frame(9'h02B, 6, 3, 1, 0, 0, 50, 8, 1, 0, "R8 stuck zero fail");
        send_frame(9'h071, 8, 4, 1, 0, 0, 50, 8, 0, 0, "R8 stuck one pass");
        send_frame(9'h071, 8, 4, 1, 0, 0, 50, 8, 1, 0, "R8 stuck one fail");
        send_frame(9'h0E7, 8, 5, 1, 0, 0, 50, 8, 1, 0, "R8 ignore flipped");
        send_frame(9'h00F, 8, 0, 2, 0, 0, 50, 8, 0, 0, "R9 two stop slots");
        send_frame(9'h080, 8, 0, 0, 0, 0, 50, 8, 0, 0, "R9 zero stop slots");
        send_frame(9'h0C3, 8, 2, 0, 0, 0, 50, 8, 0, 0, "R9 parity then no stop");
        send_frame(9'h05A, 8, 0, 2, 0, 0, 50, 8, 0, 1, "R10 first of two stops low");
        send_frame(9'h05A, 8, 0, 1, 0, 0, 50, 8, 0, 1, "R10 single stop low");
        glitch(50, 8, "R5 bad start");
        send_frame(9'h099, 8, 0, 1, 0, 0, 50, 8, 0, 0, "R5 hunting resumes");
        send_frame(9'h06E, 8, 1, 1, 0, 1, 50, 8, 0, 0, "R2 inverted line");
        send_frame(9'h033, 8, 0, 1, 0, 0, 0, 10, 0, 0, "R4 pct 0 falls back");
        send_frame(9'h0CC, 8, 0, 1, 0, 0, 120, 10, 0, 0, "R4 pct 120 falls back");
        send_frame(9'h0B2, 8, 0, 1, 0, 0, 1, 10, 0, 0, "R3 pct 1");
        send_frame(9'h04D, 8, 0, 1, 0, 0, 99, 10, 0, 0, "R3 pct 99");
        send_frame(9'h116, 9, 2, 2, 1, 0, 99, 5, 0, 0, "R3 R6 short cell pct 99");

        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule